// File: doc/BRIEF.md
# Flash Cycle Sequencer

This block lets a host run one flash operation at a time (read, program or block erase) through four registers on a small register bus. The host loads a 24-bit linear flash address and, for a program, the data word. It then writes the control register with an operation type, a byte count and the start bit. The sequencer latches the request and presents it on a simple request/acknowledge memory port. It then reports the outcome through sticky status flags that software clears by writing ones.

Every cycle is guarded. It cannot start while another cycle runs, while the hardware-sequencing-valid input is low, with the reserved operation code, or as an erase while the reported erase granularity is the invalid code. If the memory port never acknowledges, a timeout ends the cycle with the done flag and the error flag both set.

Register map (2-bit bus address): 0 status, 1 control, 2 address, 3 data. Reads are combinational from the current address; writes take effect at the clock edge where `bus_we` is high.

Top module: `flseq_top`

## Requirements
- R1: After reset, status reads 0 except bit 15 (sequencing-valid input) and bits 4:3 (granularity input). Control, address and data read 0, and `fl_req` is low.
- R2: A control write with bit 0 set, while idle with sequencing valid and an allowed operation, raises `fl_req` and status bit 5 (busy) from the next edge. `fl_op`, `fl_addr` and `fl_two` then carry control bits 2:1, the address register and control bit 8.
- R3: The edge at which `fl_ack` is high during a request ends the cycle. `fl_req` and busy drop, and status bit 0 (done) is set with status bit 1 (cycle error) unchanged.
- R4: Control bit 8 is the byte count minus one. A completed read loads the data register with `{16'h0, fl_rdata}` for two bytes or `{24'h0, fl_rdata[7:0]}` for one byte. A program drives `fl_wdata` with data bits 15:0, or `{8'h0, data[7:0]}` for one byte, and leaves the data register unchanged.
- R5: Operation codes in control bits 2:1 are 00 read, 10 program and 11 block erase. Code 01 starts no cycle and sets status bit 2 (access error).
- R6: A request that sees no acknowledge ends after exactly TMO_CYCLES request cycles with done and cycle error both set.
- R7: Writing 1 to status bit 0, 1 or 2 clears that flag, and writing 0 leaves it. When a setting event and a clear of the same flag fall at one edge, the flag ends set.
- R8: Done stays set when a new cycle starts; only a write-one clears it.
- R9: A control write while busy is ignored (operation and count stay the same and the running request is untouched). If it has bit 0 set, it sets access error.
- R10: With the sequencing-valid input low, a start request launches nothing and sets no flag.
- R11: Status bits 4:3 show the erase-granularity input (00 256 B, 01 4 KB, 11 64 KB, 10 invalid). An erase requested while it reads 10 starts no cycle and sets access error.
- R12: Status bit 15 follows the sequencing-valid input, and status bit 5 is high exactly while a request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| desc_ok | input | 1 | Hardware sequencing available |
| erase_gran | input | 2 | Erase granularity code from the flash |
| fl_req | output | 1 | Memory port request |
| fl_ack | input | 1 | Memory port acknowledge |
| fl_op | output | 2 | Operation of the current request |
| fl_addr | output | 24 | Linear flash address |
| fl_wdata | output | 16 | Program data, low byte first |
| fl_rdata | input | 16 | Read data, low byte first |
| fl_two | output | 1 | Byte count minus one |

## Verification
Cycle completion and a software write-one-to-clear of the done flag can land on the same clock edge. The bench provokes this by raising `fl_ack` in the same cycle as a status write of 1 to bit 0. It then judges the status read-back, which must still show done set. A control write that arrives while a request is outstanding is also exercised. It must leave the latched request on the port untouched and only raise the access-error flag. A behavioural model compares every port and the selected register on each clock.

// File: rtl/flseq_pkg.sv
`timescale 1ns/1ps
package flseq_pkg;
    localparam int FLASH_AW = 24;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_RSVD  = 2'b01,
        OP_WRITE = 2'b10,
        OP_ERASE = 2'b11
    } flop_e;

    localparam logic [1:0] RA_STAT = 2'd0;
    localparam logic [1:0] RA_CTRL = 2'd1;
    localparam logic [1:0] RA_ADDR = 2'd2;
    localparam logic [1:0] RA_DATA = 2'd3;

    localparam int SB_DONE = 0;
    localparam int SB_CERR = 1;
    localparam int SB_AERR = 2;
    localparam int SB_GRAN = 3;
    localparam int SB_BUSY = 5;
    localparam int SB_DVAL = 15;
    localparam int CB_GO   = 0;
    localparam int CB_OP   = 1;
    localparam int CB_TWO  = 8;

    localparam logic [1:0] GRAN_BAD = 2'b10;

    typedef struct packed {
        flop_e               op;
        logic                two;
        logic [FLASH_AW-1:0] addr;
        logic [15:0]         wdata;
    } cyc_t;

    function automatic logic op_allowed(flop_e op, logic [1:0] gran);
        return !(op == OP_RSVD || (op == OP_ERASE && gran == GRAN_BAD));
    endfunction

    function automatic logic [15:0] pack_wdata(logic two, logic [31:0] d);
        return two ? d[15:0] : {8'h00, d[7:0]};
    endfunction

    function automatic logic [31:0] unpack_rdata(logic two, logic [15:0] r);
        return two ? {16'h0000, r} : {24'h000000, r[7:0]};
    endfunction
endpackage

// File: rtl/flseq_timer.sv
`timescale 1ns/1ps
module flseq_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic hit
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/flseq_engine.sv
`timescale 1ns/1ps
module flseq_engine
    import flseq_pkg::*;
#(
    parameter int TMO = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  cyc_t cyc_in,
    input  logic fl_ack,
    output cyc_t cyc_out,
    output logic busy,
    output logic fin,
    output logic fin_err
);
    typedef enum logic {ST_IDLE, ST_WAIT} st_e;

    st_e  state;
    logic tmo_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cyc_out <= '0;
        end else if (state == ST_IDLE && start) begin
            state   <= ST_WAIT;
            cyc_out <= cyc_in;
        end else if (fin) begin
            state <= ST_IDLE;
        end
    end

    flseq_timer #(.LIMIT(TMO)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .step (state == ST_WAIT && !fl_ack),
        .hit  (tmo_hit)
    );

    assign busy    = (state == ST_WAIT);
    assign fin     = busy && (fl_ack || tmo_hit);
    assign fin_err = fin && !fl_ack;
endmodule

// File: rtl/flseq_top.sv
`timescale 1ns/1ps
module flseq_top
    import flseq_pkg::*;
#(
    parameter int TMO_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        desc_ok,
    input  logic [1:0]  erase_gran,
    output logic        fl_req,
    input  logic        fl_ack,
    output logic [1:0]  fl_op,
    output logic [23:0] fl_addr,
    output logic [15:0] fl_wdata,
    input  logic [15:0] fl_rdata,
    output logic        fl_two
);
    logic        done_q, cerr_q, aerr_q;
    flop_e       op_q;
    logic        two_q;
    logic [23:0] addr_q;
    logic [31:0] data_q;
    logic        busy, fin, fin_err;
    cyc_t        cyc_in, cyc_out;

    logic  wr_stat, wr_ctrl, wr_addr, wr_data, go_req, launch, refuse;
    flop_e wr_op;

    assign wr_stat = bus_we && bus_addr == RA_STAT;
    assign wr_ctrl = bus_we && bus_addr == RA_CTRL;
    assign wr_addr = bus_we && bus_addr == RA_ADDR;
    assign wr_data = bus_we && bus_addr == RA_DATA;
    assign wr_op   = flop_e'(bus_wdata[CB_OP +: 2]);
    assign go_req  = wr_ctrl && bus_wdata[CB_GO];
    assign launch  = go_req && !busy && desc_ok && op_allowed(wr_op, erase_gran);
    assign refuse  = go_req && (busy || (desc_ok && !op_allowed(wr_op, erase_gran)));

    always_comb begin
        cyc_in.op    = wr_op;
        cyc_in.two   = bus_wdata[CB_TWO];
        cyc_in.addr  = addr_q;
        cyc_in.wdata = pack_wdata(bus_wdata[CB_TWO], data_q);
    end

    flseq_engine #(.TMO(TMO_CYCLES)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (launch),
        .cyc_in  (cyc_in),
        .fl_ack  (fl_ack),
        .cyc_out (cyc_out),
        .busy    (busy),
        .fin     (fin),
        .fin_err (fin_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            cerr_q <= 1'b0;
            aerr_q <= 1'b0;
            op_q   <= OP_READ;
            two_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (wr_ctrl && !busy) begin
                op_q  <= wr_op;
                two_q <= bus_wdata[CB_TWO];
            end
            if (wr_addr) addr_q <= bus_wdata[23:0];
            if (wr_data) data_q <= bus_wdata;
            if (fin && !fin_err && cyc_out.op == OP_READ)
                data_q <= unpack_rdata(cyc_out.two, fl_rdata);
            done_q <= fin | (done_q & ~(wr_stat & bus_wdata[SB_DONE]));
            cerr_q <= fin_err | (cerr_q & ~(wr_stat & bus_wdata[SB_CERR]));
            aerr_q <= refuse | (aerr_q & ~(wr_stat & bus_wdata[SB_AERR]));
        end
    end

    logic [15:0] stat_w, ctrl_w;
    always_comb begin
        stat_w = '0;
        stat_w[SB_DONE]      = done_q;
        stat_w[SB_CERR]      = cerr_q;
        stat_w[SB_AERR]      = aerr_q;
        stat_w[SB_GRAN +: 2] = erase_gran;
        stat_w[SB_BUSY]      = busy;
        stat_w[SB_DVAL]      = desc_ok;
        ctrl_w = '0;
        ctrl_w[CB_OP +: 2]   = op_q;
        ctrl_w[CB_TWO]       = two_q;
        case (bus_addr)
            RA_STAT: bus_rdata = {16'h0000, stat_w};
            RA_CTRL: bus_rdata = {16'h0000, ctrl_w};
            RA_ADDR: bus_rdata = {8'h00, addr_q};
            default: bus_rdata = data_q;
        endcase
    end

    assign fl_req   = busy;
    assign fl_op    = cyc_out.op;
    assign fl_addr  = cyc_out.addr;
    assign fl_wdata = cyc_out.wdata;
    assign fl_two   = cyc_out.two;
endmodule

// File: rtl/flseq_chk.sv
`timescale 1ns/1ps
module flseq_chk #(
    parameter int TMO = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_we,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        desc_ok,
    input logic        fl_req,
    input logic        fl_ack,
    input logic [23:0] fl_addr,
    input logic [1:0]  fl_op,
    input logic        done_q,
    input logic        cerr_q,
    input logic        aerr_q
);
    logic [31:0] run;
    always_ff @(posedge clk) begin
        if (rst) run <= '0;
        else     run <= fl_req ? run + 1 : '0;
    end

    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        fl_req |=> ($stable(fl_addr) && $stable(fl_op)));

    p_ack_done_r3: assert property (@(posedge clk) disable iff (rst)
        (fl_req && fl_ack) |=> (done_q && !fl_req));

    p_req_bound_r6: assert property (@(posedge clk) disable iff (rst)
        fl_req |-> (run < TMO));

    p_tmo_err_r6: assert property (@(posedge clk) disable iff (rst)
        (fl_req && !fl_ack && run == TMO - 1) |=> (cerr_q && done_q && !fl_req));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (done_q && !(bus_we && bus_addr == 2'd0 && bus_wdata[0])) |=> done_q);

    p_busy_go_r9: assert property (@(posedge clk) disable iff (rst)
        (fl_req && bus_we && bus_addr == 2'd1 && bus_wdata[0]) |=> aerr_q);

    p_no_desc_r10: assert property (@(posedge clk) disable iff (rst)
        (!desc_ok && !fl_req) |=> !fl_req);
endmodule

bind flseq_top flseq_chk #(.TMO(TMO_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .desc_ok   (desc_ok),
    .fl_req    (fl_req),
    .fl_ack    (fl_ack),
    .fl_addr   (fl_addr),
    .fl_op     (fl_op),
    .done_q    (done_q),
    .cerr_q    (cerr_q),
    .aerr_q    (aerr_q)
);

// File: tb/sim_flseq_top.sv
`timescale 1ns/1ps
module sim_flseq_top;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst, bus_we, desc_ok, fl_ack, fl_req, fl_two;
    logic [1:0]  bus_addr, erase_gran, fl_op;
    logic [31:0] bus_wdata, bus_rdata;
    logic [23:0] fl_addr;
    logic [15:0] fl_wdata, fl_rdata;

    always #2.5 clk = ~clk;

    flseq_top #(.TMO_CYCLES(TMO)) u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .desc_ok(desc_ok),
        .erase_gran(erase_gran), .fl_req(fl_req), .fl_ack(fl_ack),
        .fl_op(fl_op), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .fl_two(fl_two)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit          m_busy, m_done, m_cerr, m_aerr, m_two, m_rtwo;
    logic [1:0]  m_op, m_rop;
    logic [23:0] m_addr, m_raddr;
    logic [31:0] m_data;
    logic [15:0] m_rwd;
    int          m_wait;

    function automatic logic [31:0] model_read(logic [1:0] a);
        case (a)
            2'd0: return {16'h0, desc_ok, 9'h0, m_busy, erase_gran, m_aerr, m_cerr, m_done};
            2'd1: return {16'h0, 7'h0, m_two, 5'h0, m_op, 1'b0};
            2'd2: return {8'h0, m_addr};
            default: return m_data;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit fin, ferr, st;
        logic [1:0] wop;
        if (rst) begin
            m_busy = 0; m_done = 0; m_cerr = 0; m_aerr = 0; m_two = 0; m_rtwo = 0;
            m_op = 0; m_rop = 0; m_addr = 0; m_raddr = 0; m_data = 0; m_rwd = 0; m_wait = 0;
        end else begin
            fin = 0; ferr = 0; st = 0; wop = bus_wdata[2:1];
            if (m_busy) begin
                if (fl_ack) fin = 1;
                else if (m_wait == TMO - 1) begin fin = 1; ferr = 1; end
                else m_wait++;
            end
            if (bus_we) begin
                case (bus_addr)
                    2'd0: begin
                        if (bus_wdata[0]) m_done = 0;
                        if (bus_wdata[1]) m_cerr = 0;
                        if (bus_wdata[2]) m_aerr = 0;
                    end
                    2'd1: begin
                        if (m_busy) begin
                            if (bus_wdata[0]) m_aerr = 1;
                        end else begin
                            m_op = wop; m_two = bus_wdata[8];
                            if (bus_wdata[0] && desc_ok) begin
                                if (wop == 2'b01 || (wop == 2'b11 && erase_gran == 2'b10)) m_aerr = 1;
                                else st = 1;
                            end
                        end
                    end
                    2'd2: m_addr = bus_wdata[23:0];
                    default: m_data = bus_wdata;
                endcase
            end
            if (fin) begin
                m_busy = 0; m_done = 1;
                if (ferr) m_cerr = 1;
                else if (m_rop == 2'b00)
                    m_data = m_rtwo ? {16'h0, fl_rdata} : {24'h0, fl_rdata[7:0]};
            end
            if (st) begin
                m_busy = 1; m_wait = 0; m_rop = wop; m_rtwo = bus_wdata[8]; m_raddr = m_addr;
                m_rwd = bus_wdata[8] ? m_data[15:0] : {8'h0, m_data[7:0]};
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R12 model fl_req", {31'h0, fl_req}, {31'h0, m_busy});
            if (m_busy) begin
                chk("R2 model fl_op", {30'h0, fl_op}, {30'h0, m_rop});
                chk("R2 model fl_addr", {8'h0, fl_addr}, {8'h0, m_raddr});
                chk("R2 model fl_two", {31'h0, fl_two}, {31'h0, m_rtwo});
                chk("R4 model fl_wdata", {16'h0, fl_wdata}, {16'h0, m_rwd});
            end
            chk("R7 model register read", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 0;
    endtask

    task automatic ack();
        fl_ack = 1;
        tick();
        fl_ack = 0;
    endtask

    task automatic expect_reg(string tag, logic [1:0] a, logic [31:0] e);
        bus_addr = a;
        #0.1;
        chk(tag, bus_rdata, e);
    endtask

    initial begin
        rst = 1; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        desc_ok = 1; erase_gran = 2'b01; fl_ack = 0; fl_rdata = 0;
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        expect_reg("R1 status after reset", 2'd0, 32'h8008);
        expect_reg("R1 control after reset", 2'd1, 32'h0);
        expect_reg("R1 address after reset", 2'd2, 32'h0);
        expect_reg("R1 data after reset", 2'd3, 32'h0);
        chk("R1 fl_req after reset", {31'h0, fl_req}, 32'h0);
        // R2 two-byte read
        wr(2'd2, 32'h0012_3456);
        wr(2'd1, 32'h0101);
        chk("R2 fl_req raised", {31'h0, fl_req}, 32'h1);
        chk("R2 fl_addr", {8'h0, fl_addr}, 32'h0012_3456);
        chk("R2 fl_op read", {30'h0, fl_op}, 32'h0);
        chk("R2 fl_two", {31'h0, fl_two}, 32'h1);
        expect_reg("R12 busy bit", 2'd0, 32'h8028);
        fl_rdata = 16'hBEEF;
        tick(); tick();
        ack();
        chk("R3 fl_req dropped", {31'h0, fl_req}, 32'h0);
        expect_reg("R3 done set", 2'd0, 32'h8009);
        expect_reg("R4 two-byte read data", 2'd3, 32'h0000_BEEF);
        // R8 done kept across a new start, one-byte read
        wr(2'd1, 32'h0001);
        expect_reg("R8 done kept at start", 2'd0, 32'h8029);
        fl_rdata = 16'hA5C3;
        ack();
        expect_reg("R4 one-byte read data", 2'd3, 32'h0000_00C3);
        expect_reg("R8 done after second cycle", 2'd0, 32'h8009);
        // R7 write-one-to-clear
        wr(2'd0, 32'h0);
        expect_reg("R7 zero write keeps done", 2'd0, 32'h8009);
        wr(2'd0, 32'h1);
        expect_reg("R7 one clears done", 2'd0, 32'h8008);
        // R4 program data packing
        wr(2'd3, 32'h1234_ABCD);
        wr(2'd1, 32'h0005);
        chk("R4 one-byte wdata", {16'h0, fl_wdata}, 32'h00CD);
        chk("R5 program op", {30'h0, fl_op}, 32'h2);
        ack();
        wr(2'd1, 32'h0105);
        chk("R4 two-byte wdata", {16'h0, fl_wdata}, 32'hABCD);
        ack();
        expect_reg("R4 program keeps data", 2'd3, 32'h1234_ABCD);
        wr(2'd0, 32'h7);
        // R9 start while busy
        wr(2'd1, 32'h0007);
        chk("R5 erase op", {30'h0, fl_op}, 32'h3);
        wr(2'd1, 32'h0101);
        expect_reg("R9 access error", 2'd0, 32'h802C);
        expect_reg("R9 control unchanged", 2'd1, 32'h0006);
        chk("R9 request untouched", {30'h0, fl_op}, 32'h3);
        ack();
        wr(2'd0, 32'h7);
        expect_reg("R7 all flags cleared", 2'd0, 32'h8008);
        // R6 timeout
        wr(2'd1, 32'h0001);
        begin
            int n = 0;
            while (fl_req && n < 100) begin n++; tick(); end
            chk("R6 timeout length", n, TMO);
        end
        expect_reg("R6 done and error", 2'd0, 32'h800B);
        wr(2'd0, 32'h7);
        // R7 completion and clear at one edge
        wr(2'd1, 32'h0101);
        tick();
        fl_ack = 1; bus_we = 1; bus_addr = 2'd0; bus_wdata = 32'h1;
        tick();
        fl_ack = 0; bus_we = 0;
        expect_reg("R7 set wins over clear", 2'd0, 32'h8009);
        wr(2'd0, 32'h7);
        // R5 reserved code
        wr(2'd1, 32'h0003);
        chk("R5 reserved starts nothing", {31'h0, fl_req}, 32'h0);
        expect_reg("R5 reserved access error", 2'd0, 32'h800C);
        wr(2'd0, 32'h7);
        // R11 granularity
        erase_gran = 2'b10;
        tick();
        expect_reg("R11 field shows invalid code", 2'd0, 32'h8010);
        wr(2'd1, 32'h0007);
        chk("R11 erase refused", {31'h0, fl_req}, 32'h0);
        expect_reg("R11 refused erase flags access error", 2'd0, 32'h8014);
        wr(2'd0, 32'h7);
        erase_gran = 2'b11;
        expect_reg("R11 field shows 64K", 2'd0, 32'h8018);
        wr(2'd1, 32'h0007);
        chk("R11 erase with 64K starts", {31'h0, fl_req}, 32'h1);
        ack();
        wr(2'd0, 32'h7);
        erase_gran = 2'b01;
        // R10 sequencing not valid
        desc_ok = 0;
        wr(2'd1, 32'h0001);
        tick();
        chk("R10 no request", {31'h0, fl_req}, 32'h0);
        expect_reg("R10 no flags", 2'd0, 32'h0008);
        desc_ok = 1;
        tick();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule